// File: doc/BRIEF.md
# Burst Address Generator with Dual Strobes

This block produces the word address presented to the array of a synchronous burst memory. On every rising clock edge it looks at an external address, two load strobes, an advance input, three chip enables and an order select. A strobe captures a new base address and starts a four-beat burst. After that, each cycle with advance asserted moves the two low address bits to the next beat, and a cycle without advance holds the burst where it is. The upper address bits never change inside a burst.

There are two load strobes. The processor-side strobe is ignored when the main chip enable is low. The controller-side strobe is always honoured. On any accepted strobe cycle all three chip enables decide the outcome: if all are high, the new address is loaded; otherwise the block is deselected. The beat order is chosen when a burst is loaded. It is either linear (base plus beat number, modulo four) or interleaved (base XOR beat number). After the fourth beat the address wraps back to the base. A strobe may be given on every cycle, so single accesses at a new address each clock need no burst at all.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `word_addr` becomes all zeros and `sel_valid` becomes 0; with no strobe and no advance afterwards, both keep those values.
- R2: A cycle with `cpu_strobe`=1 and `ce_main`, `ce_aux_a` and `ce_aux_b` all 1 loads `addr_in`. On the next cycle `word_addr` equals that address and `sel_valid`=1.
- R3: A cycle with `ctl_strobe`=1 and all three chip enables at 1 loads `addr_in` in the same way, whatever the level of `cpu_strobe`.
- R4: `cpu_strobe` has no effect in a cycle where `ce_main`=0. If `ctl_strobe`=0 in that cycle, the address and flag either hold (`advance`=0) or take the next burst beat (`advance`=1) exactly as if `cpu_strobe` were 0.
- R5: An accepted strobe cycle (`ctl_strobe`=1, or `cpu_strobe`=1 with `ce_main`=1) with any chip enable at 0 clears `sel_valid` on the next cycle.
- R6: `ce_aux_a` and `ce_aux_b` are ignored in cycles without an accepted strobe. The burst keeps stepping or holding, and `sel_valid` stays at 1.
- R7: With `order_linear`=1 at load time, the n-th advance (n = 1..3) after a load gives low bits (base[1:0] + n) mod 4.
- R8: With `order_linear`=0 at load time (the default interleaved order), the n-th advance gives low bits base[1:0] XOR n.
- R9: On the fourth advance the low bits return to base[1:0]. Bits above bit 1 equal the loaded address on every beat.
- R10: A cycle with `advance`=0 and no accepted strobe keeps `word_addr` and `sel_valid` unchanged (burst suspended). A later advance resumes from the held beat.
- R11: An accepted strobe takes precedence over `advance`, so a strobe on consecutive cycles loads a fresh address each cycle. When both strobes are accepted together, `addr_in` is loaded.
- R12: A change of `order_linear` after the load does not change the order of the running burst.
- R13: While deselected, `advance` has no effect: `word_addr` and `sel_valid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address loaded by a strobe |
| cpu_strobe | input | 1 | Processor-side load strobe, masked by `ce_main` low |
| ctl_strobe | input | 1 | Controller-side load strobe |
| advance | input | 1 | Steps the burst to its next beat |
| ce_main | input | 1 | Main chip enable, active high |
| ce_aux_a | input | 1 | Secondary chip enable, used only on strobe cycles |
| ce_aux_b | input | 1 | Secondary chip enable, used only on strobe cycles |
| order_linear | input | 1 | 1 = linear beat order, 0 = interleaved; captured at load |
| word_addr | output | ADDR_W | Current array word address |
| sel_valid | output | 1 | Block selected and address valid |

## Verification
The bench builds the block with `ADDR_W` = 10. This keeps the address narrow enough that each base pattern makes the upper bits distinct from the beat bits. The bench loads every one of the four low-bit starting positions under both beat orders and alternates between the two strobes. Each of these bursts is walked through the wrap. On top of that come targeted sequences: a masked processor strobe, deselects caused by each kind of enable, a mid-burst order flip, and strobes on back-to-back cycles.

// File: rtl/bag_pkg.sv
package bag_pkg;

    // number of address bits covered by the burst counter
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // action selected for the coming clock edge
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;

    // low-bit offset of beat n relative to a base, in the chosen order
    function automatic beat_t beat_offset(beat_t base, beat_t n, logic linear);
        beat_t r;
        if (linear) r = beat_t'(base + n);
        else        r = base ^ n;
        return r;
    endfunction

endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
    import bag_pkg::*;
(
    input  logic cpu_strobe,
    input  logic ctl_strobe,
    input  logic advance,
    input  logic ce_main,
    input  logic ce_aux_a,
    input  logic ce_aux_b,
    input  logic active,
    output cmd_e cmd,
    output logic from_cpu
);

    logic cpu_ok;
    logic start;
    logic all_en;

    always_comb begin
        // processor strobe is masked by the main enable
        cpu_ok   = cpu_strobe & ce_main;
        start    = cpu_ok | ctl_strobe;
        all_en   = ce_main & ce_aux_a & ce_aux_b;
        from_cpu = cpu_ok;
        if (start) begin
            cmd = all_en ? CMD_LOAD : CMD_DESEL;
        end else if (advance && active) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/bag_burst_state.sv
module bag_burst_state
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cmd_e                     cmd,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic                     order_linear,
    output logic [ADDR_W-BEAT_W-1:0] base_hi,
    output beat_t                    base_lo,
    output beat_t                    beat,
    output logic                     lin,
    output logic                     valid
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic            valid;
        logic            lin;
        logic [HI_W-1:0] hi;
        beat_t           lo;
        beat_t           beat;
    } burst_state_t;

    burst_state_t st_q;
    burst_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.valid = 1'b1;
                st_d.lin   = order_linear;
                st_d.hi    = addr_in[ADDR_W-1:BEAT_W];
                st_d.lo    = addr_in[BEAT_W-1:0];
                st_d.beat  = '0;
            end
            CMD_DESEL: begin
                st_d.valid = 1'b0;
            end
            CMD_STEP: begin
                st_d.beat = beat_t'(st_q.beat + 1'b1);
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign base_hi = st_q.hi;
    assign base_lo = st_q.lo;
    assign beat    = st_q.beat;
    assign lin     = st_q.lin;
    assign valid   = st_q.valid;

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import bag_pkg::*;
(
    input  beat_t base_lo,
    input  beat_t beat,
    input  logic  lin,
    output beat_t lo_out
);

    always_comb begin
        lo_out = beat_offset(base_lo, beat, lin);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              advance,
    input  logic              ce_main,
    input  logic              ce_aux_a,
    input  logic              ce_aux_b,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] word_addr,
    output logic              sel_valid
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_e            cmd;
    logic            from_cpu;
    logic            active;
    logic [HI_W-1:0] base_hi;
    beat_t           base_lo;
    beat_t           beat;
    logic            lin;
    beat_t           lo_out;

    bag_strobe_arb u_arb (
        .cpu_strobe (cpu_strobe),
        .ctl_strobe (ctl_strobe),
        .advance    (advance),
        .ce_main    (ce_main),
        .ce_aux_a   (ce_aux_a),
        .ce_aux_b   (ce_aux_b),
        .active     (active),
        .cmd        (cmd),
        .from_cpu   (from_cpu)
    );

    bag_burst_state #(.ADDR_W(ADDR_W)) u_state (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .addr_in      (addr_in),
        .order_linear (order_linear),
        .base_hi      (base_hi),
        .base_lo      (base_lo),
        .beat         (beat),
        .lin          (lin),
        .valid        (active)
    );

    bag_order_map u_map (
        .base_lo (base_lo),
        .beat    (beat),
        .lin     (lin),
        .lo_out  (lo_out)
    );

    assign word_addr = {base_hi, lo_out};
    assign sel_valid = active;

endmodule

// File: rtl/bag_checker.sv
module bag_checker
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              cpu_strobe,
    input logic              ctl_strobe,
    input logic              advance,
    input logic              ce_main,
    input logic              ce_aux_a,
    input logic              ce_aux_b,
    input logic [ADDR_W-1:0] word_addr,
    input logic              sel_valid
);

    logic acc_start;
    logic all_en;
    assign acc_start = (cpu_strobe & ce_main) | ctl_strobe;
    assign all_en    = ce_main & ce_aux_a & ce_aux_b;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!sel_valid && word_addr == '0));

    assert_load_cpu_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && all_en) |=> (sel_valid && word_addr == $past(addr_in)));

    assert_load_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe && all_en) |=> (sel_valid && word_addr == $past(addr_in)));

    assert_masked_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && !ce_main && !ctl_strobe && !advance)
        |=> ($stable(word_addr) && $stable(sel_valid)));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_start && !all_en) |=> !sel_valid);

    assert_step_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (!acc_start && advance && sel_valid)
        |=> (sel_valid && word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W])));

    assert_suspend_R10: assert property (@(posedge clk) disable iff (rst)
        (!acc_start && !advance) |=> ($stable(word_addr) && $stable(sel_valid)));

    assert_idle_desel_R13: assert property (@(posedge clk) disable iff (rst)
        (!acc_start && !sel_valid) |=> ($stable(word_addr) && !sel_valid));

endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_bag_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (addr_in),
    .cpu_strobe (cpu_strobe),
    .ctl_strobe (ctl_strobe),
    .advance    (advance),
    .ce_main    (ce_main),
    .ce_aux_a   (ce_aux_a),
    .ce_aux_b   (ce_aux_b),
    .word_addr  (word_addr),
    .sel_valid  (sel_valid)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] a   = '0;
    logic          cs_p = 1'b0, cs_c = 1'b0, adv = 1'b0;
    logic          e1 = 1'b1, e2 = 1'b1, e3 = 1'b1;
    logic          lin = 1'b0;
    logic [AW-1:0] wa;
    logic          v;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (a),
        .cpu_strobe   (cs_p),
        .ctl_strobe   (cs_c),
        .advance      (adv),
        .ce_main      (e1),
        .ce_aux_a     (e2),
        .ce_aux_b     (e3),
        .order_linear (lin),
        .word_addr    (wa),
        .sel_valid    (v)
    );

    task automatic idle();
        cs_p = 0; cs_c = 0; adv = 0; e1 = 1; e2 = 1; e3 = 1;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk(string req, logic [AW-1:0] ea, logic ev);
        checks++;
        if (wa !== ea || v !== ev) begin
            errors++;
            $display("FAIL %s: addr=%0h valid=%0b expected addr=%0h valid=%0b",
                     req, wa, v, ea, ev);
        end
    endtask

    task automatic chk_v(string req, logic ev);
        checks++;
        if (v !== ev) begin
            errors++;
            $display("FAIL %s: valid=%0b expected valid=%0b", req, v, ev);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int n, logic l);
        logic [1:0] nn, lo;
        nn = n[1:0];
        lo = l ? 2'(b[1:0] + nn) : (b[1:0] ^ nn);
        return {b[AW-1:2], lo};
    endfunction

    task automatic load(logic [AW-1:0] b, logic l, bit use_ctl);
        idle(); a = b; lin = l;
        if (use_ctl) cs_c = 1; else cs_p = 1;
        tick();
        chk(use_ctl ? "R3 load" : "R2 load", b, 1'b1);
        idle();
    endtask

    task automatic t_reset();
        rst = 1; idle(); a = '0; lin = 0;
        tick(); tick();
        chk("R1 in reset", '0, 1'b0);
        rst = 0;
        tick();
        chk("R1 after reset", '0, 1'b0);
    endtask

    task automatic t_burst(logic [AW-1:0] b, logic l, bit use_ctl);
        load(b, l, use_ctl);
        a = ~b;
        adv = 1;
        for (int n = 1; n <= 4; n++) begin
            tick();
            if (n == 4) chk("R9 wrap", b, 1'b1);
            else chk(l ? "R7 linear" : "R8 interleaved", beat_addr(b, n, l), 1'b1);
        end
        adv = 0;
    endtask

    task automatic t_suspend();
        load(10'h1C6, 1'b1, 0);
        adv = 1; tick(); chk("R10 first step", 10'h1C7, 1'b1);
        adv = 0; a = 10'h3FF;
        tick(); chk("R10 hold", 10'h1C7, 1'b1);
        tick(); chk("R10 hold", 10'h1C7, 1'b1);
        adv = 1; tick(); chk("R10 resume", 10'h1C4, 1'b1);
        adv = 0;
    endtask

    task automatic t_mask();
        load(10'h0F1, 1'b0, 0);
        cs_p = 1; e1 = 0; a = 10'h333; adv = 0;
        tick(); chk("R4 masked hold", 10'h0F1, 1'b1);
        adv = 1;
        tick(); chk("R4 masked step", 10'h0F0, 1'b1);
        idle();
    endtask

    task automatic t_desel();
        load(10'h155, 1'b1, 0);
        cs_p = 1; e2 = 0; a = 10'h2AA;
        tick(); chk_v("R5 cpu aux_a low", 1'b0);
        idle(); adv = 1;
        tick(); chk("R13 advance while off", 10'h155, 1'b0);
        tick(); chk("R13 advance while off", 10'h155, 1'b0);
        adv = 0;
        load(10'h0AA, 1'b0, 1);
        cs_c = 1; e1 = 0;
        tick(); chk_v("R5 ctl main low", 1'b0);
        load(10'h0AB, 1'b0, 0);
        cs_p = 1; e3 = 0;
        tick(); chk_v("R5 cpu aux_b low", 1'b0);
        idle();
    endtask

    task automatic t_aux_ignored();
        load(10'h208, 1'b1, 0);
        e2 = 0; e3 = 0; adv = 1;
        tick(); chk("R6 step with aux low", 10'h209, 1'b1);
        adv = 0;
        tick(); chk("R6 hold with aux low", 10'h209, 1'b1);
        idle();
    endtask

    task automatic t_b2b();
        idle(); adv = 1; lin = 0;
        cs_p = 1; a = 10'h101; tick(); chk("R11 b2b cpu", 10'h101, 1'b1);
        a = 10'h3FE; tick(); chk("R11 b2b cpu", 10'h3FE, 1'b1);
        cs_p = 0; cs_c = 1; a = 10'h07D; tick(); chk("R11 b2b ctl", 10'h07D, 1'b1);
        cs_p = 1; a = 10'h222; tick(); chk("R11 both strobes", 10'h222, 1'b1);
        idle();
    endtask

    task automatic t_order_latch();
        load(10'h043, 1'b1, 0);
        lin = 0; adv = 1;
        tick(); chk("R12 order kept", 10'h040, 1'b1);
        tick(); chk("R12 order kept", 10'h041, 1'b1);
        tick(); chk("R12 order kept", 10'h042, 1'b1);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        for (int b = 0; b < 4; b++) begin
            for (int l = 0; l < 2; l++) begin
                t_burst(10'h2B4 | AW'(b), l[0], b[0]);
            end
        end
        t_suspend();
        t_mask();
        t_desel();
        t_aux_ignored();
        t_b2b();
        t_order_latch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule